// File: doc/BRIEF.md
# Write Burst Beat and Lane Monitor

This block watches the write address, write data and write response channels of a slave that accepts write data without interleaving. Every accepted write address enters a small ordered queue. Data beats are counted and compared against the oldest queued address. Each rule violation sets its own sticky error flag. The block drives nothing back onto the bus, so it can sit beside any slave port as a passive observer.

A data burst may finish before its address arrives. Its beat count is then held until the next address is accepted and compared with that address's length. For each beat the block computes the byte address from the burst's start offset, transfer size, burst type and beat number. It turns that byte address into the set of byte lanes the beat may use, and any strobe bit outside that set is an error. A write response given while no data burst is complete is also flagged.

Top module: `wbeat_monitor`

## Requirements
- R1: A beat with `w_last` high whose zero-based index within its burst differs from the `aw_len` of the oldest pending address sets `err_last_bad` one cycle after the beat.
- R2: A beat with `w_last` low whose zero-based index equals the oldest pending address's `aw_len` sets `err_last_absent` one cycle after the beat.
- R3: When a burst ends with `w_last` while no address is pending, its index of last beat is held; the next accepted address is matched against it instead of being queued, and a mismatch with that address's `aw_len` sets `err_last_bad`.
- R4: A beat whose `w_id` differs from the ID of the oldest pending address sets `err_order`.
- R5: `aw_burst` 2'b01 is incrementing, `aw_size` code k means 2^k bytes per beat, and byte lane i carries byte address i modulo (DATA_W/8). Beat 0 may use only the lanes from its start byte up to the next size boundary. Beat n>0 uses the full size-aligned slot at aligned start + n*2^k. A strobe bit set outside the legal lanes sets `err_strb`.
- R6: For `aw_burst` 2'b00 (fixed) every beat repeats the start address. For 2'b10 (wrapping) beat addresses wrap inside the window of (aw_len+1)*2^k bytes that contains the start. Strobes are judged against these addresses as in R5.
- R7: A write response handshake (`b_valid` and `b_ready`) at a time when no completed data burst is awaiting a response sets `err_resp_early`; a response in the same cycle as the `w_last` beat counts as early.
- R8: The address queue holds MAX_BURSTS entries. An address accepted while the queue is full and nothing leaves it sets `err_queue`. A second burst that ends with no address pending while a held count from R3 is still unmatched also sets `err_queue`.
- R9: An address accepted in the same cycle as a data beat, with the queue empty, applies to that beat. If that beat carries `w_last`, the address is retired at once and never queued.
- R10: All flags are 0 after the synchronous active-high `rst`, and once set a flag stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_addr_lo | input | 12 | Low 12 bits of the write start address |
| aw_len | input | 4 | Beats in burst minus one |
| aw_size | input | 3 | Log2 of bytes per beat |
| aw_burst | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_id | input | ID_W | Write data ID |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Last beat of burst |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| err_last_bad | output | 1 | Sticky: last beat at wrong position or held count mismatch |
| err_last_absent | output | 1 | Sticky: expected last beat missing |
| err_order | output | 1 | Sticky: data ID does not match oldest address |
| err_strb | output | 1 | Sticky: strobe on an illegal lane |
| err_resp_early | output | 1 | Sticky: response before burst completion |
| err_queue | output | 1 | Sticky: address queue or held-count overflow |

## Verification
Two pairs of functions can coincide in one cycle. Address acceptance can coincide with a data beat while the queue is empty, and a last beat can coincide with a response handshake. The bench drives an address and a single-beat burst in the same cycle. It judges by the strobe check, which must use the address that arrived in that cycle. A later address-less burst must then raise no order error, which shows the address was not also queued. It also drives `w_last` and a response together and expects the early-response flag, since the beat had not yet completed before that edge.

// File: rtl/wbeat_pkg.sv
package wbeat_pkg;

    localparam int LEN_W   = 4;
    localparam int SIZE_W  = 3;
    localparam int OFS_W   = 12;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [LEN_W-1:0]  len;
        logic [SIZE_W-1:0] size;
        burst_e            burst;
    } addr_info_t;

    typedef struct packed {
        logic queue;
        logic resp;
        logic strb;
        logic order;
        logic absent;
        logic bad;
    } err_flags_t;

    // byte offset of beat n of a burst, kept to OFS_W bits
    function automatic logic [OFS_W-1:0] beat_offset(addr_info_t a, logic [OFS_W-1:0] n);
        logic [OFS_W-1:0] step;
        logic [OFS_W-1:0] aligned;
        logic [OFS_W-1:0] lin;
        logic [OFS_W-1:0] win;
        logic [OFS_W-1:0] lower;
        logic [OFS_W-1:0] r;
        step    = OFS_W'(1) << a.size;
        aligned = a.ofs & ~(step - OFS_W'(1));
        lin     = aligned + (n << a.size);
        win     = ({{(OFS_W-LEN_W){1'b0}}, a.len} + OFS_W'(1)) << a.size;
        lower   = a.ofs & ~(win - OFS_W'(1));
        case (a.burst)
            BURST_FIXED: r = a.ofs;
            BURST_WRAP:  r = (n == '0) ? a.ofs
                                       : lower + ((lin - lower) & (win - OFS_W'(1)));
            default:     r = (n == '0) ? a.ofs : lin;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wbeat_fifo.sv
module wbeat_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          wr_en, rd_en;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign rd_en    = pop & ~empty;
    assign wr_en    = push & (~full | rd_en);
    assign overflow = push & full & ~rd_en;
    assign dout     = mem[rd_ptr];

    function automatic logic [PW-1:0] next_ptr(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= next_ptr(wr_ptr);
            if (rd_en) rd_ptr <= next_ptr(rd_ptr);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/wbeat_beat_ctr.sv
module wbeat_beat_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             last,
    output logic [CNT_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (fire) begin
            if (last)            idx <= '0;
            else if (idx != '1)  idx <= idx + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wbeat_resp_track.sv
module wbeat_resp_track #(
    parameter int W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic resp,
    output logic none_done
);
    logic [W-1:0] pending;
    logic         inc, dec;

    assign none_done = (pending == '0);
    assign dec       = resp & ~none_done;
    assign inc       = done & (pending != '1);

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= pending + W'(inc) - W'(dec);
    end
endmodule

// File: rtl/wbeat_lane_mask.sv
module wbeat_lane_mask
    import wbeat_pkg::*;
#(
    parameter int LANES = 4
) (
    input  addr_info_t         info,
    input  logic [OFS_W-1:0]   beat,
    output logic [LANES-1:0]   mask
);
    localparam logic [OFS_W-1:0] LMASK = OFS_W'(LANES - 1);

    logic [OFS_W-1:0] ofs, step, aligned, lo, hi;

    always_comb begin
        ofs     = beat_offset(info, beat);
        step    = OFS_W'(1) << info.size;
        aligned = ofs & ~(step - OFS_W'(1));
        lo      = ofs & LMASK;
        if (step >= OFS_W'(LANES)) hi = LMASK;
        else                       hi = (aligned & LMASK) + step - OFS_W'(1);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (OFS_W'(i) >= lo) && (OFS_W'(i) <= hi);
    end
endmodule

// File: rtl/wbeat_monitor.sv
module wbeat_monitor
    import wbeat_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int DATA_W     = 32,
    parameter int MAX_BURSTS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                aw_valid,
    input  logic                aw_ready,
    input  logic [ID_W-1:0]     aw_id,
    input  logic [OFS_W-1:0]    aw_addr_lo,
    input  logic [LEN_W-1:0]    aw_len,
    input  logic [SIZE_W-1:0]   aw_size,
    input  logic [1:0]          aw_burst,
    input  logic                w_valid,
    input  logic                w_ready,
    input  logic [ID_W-1:0]     w_id,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    input  logic                b_valid,
    input  logic                b_ready,
    output logic                err_last_bad,
    output logic                err_last_absent,
    output logic                err_order,
    output logic                err_strb,
    output logic                err_resp_early,
    output logic                err_queue
);
    localparam int LANES   = DATA_W / 8;
    localparam int CNT_W   = LEN_W + 2;
    localparam int INFO_W  = $bits(addr_info_t);
    localparam int ENTRY_W = ID_W + INFO_W;
    localparam int RESP_W  = $clog2(MAX_BURSTS) + 2;

    logic aw_fire, w_fire, b_fire;
    assign aw_fire = aw_valid & aw_ready;
    assign w_fire  = w_valid & w_ready;
    assign b_fire  = b_valid & b_ready;

    addr_info_t aw_info;
    assign aw_info = '{ofs: aw_addr_lo, len: aw_len, size: aw_size, burst: burst_e'(aw_burst)};

    // address queue
    logic               q_push, q_pop, q_empty, q_full, q_ovf;
    logic [ENTRY_W-1:0] q_dout;
    logic [ID_W-1:0]    q_id;
    addr_info_t         q_info;

    // held count of a burst that finished before its address
    logic               orphan_valid;
    logic [CNT_W-1:0]   orphan_idx;
    logic               orphan_hit, orphan_new, orphan_ovf;

    // resolved oldest address for the current beat
    logic               bypass, head_valid;
    logic [ID_W-1:0]    head_id;
    addr_info_t         head_info;
    logic [CNT_W-1:0]   head_len_ext;

    logic [CNT_W-1:0]   beat_idx;
    logic [LANES-1:0]   lane_ok;
    logic               resp_none;

    assign {q_id, q_info} = q_dout;

    assign orphan_hit = aw_fire & orphan_valid;
    assign bypass     = aw_fire & ~orphan_valid & q_empty;
    assign head_valid = ~q_empty | bypass;

    always_comb begin
        if (q_empty) begin
            head_id   = aw_id;
            head_info = aw_info;
        end else begin
            head_id   = q_id;
            head_info = q_info;
        end
        head_len_ext = CNT_W'(head_info.len);
    end

    assign q_push = aw_fire & ~orphan_valid & ~(bypass & w_fire & w_last);
    assign q_pop  = w_fire & w_last & ~q_empty;

    assign orphan_new = w_fire & w_last & ~head_valid;
    assign orphan_ovf = orphan_new & orphan_valid & ~orphan_hit;

    wbeat_fifo #(.W(ENTRY_W), .DEPTH(MAX_BURSTS)) u_addr_q (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .pop      (q_pop),
        .din      ({aw_id, aw_info}),
        .dout     (q_dout),
        .empty    (q_empty),
        .full     (q_full),
        .overflow (q_ovf)
    );

    wbeat_beat_ctr #(.CNT_W(CNT_W)) u_beat_ctr (
        .clk  (clk),
        .rst  (rst),
        .fire (w_fire),
        .last (w_last),
        .idx  (beat_idx)
    );

    wbeat_lane_mask #(.LANES(LANES)) u_lanes (
        .info (head_info),
        .beat (OFS_W'(beat_idx)),
        .mask (lane_ok)
    );

    wbeat_resp_track #(.W(RESP_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .done      (w_fire & w_last),
        .resp      (b_fire),
        .none_done (resp_none)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            orphan_valid <= 1'b0;
            orphan_idx   <= '0;
        end else if (orphan_new && (!orphan_valid || orphan_hit)) begin
            orphan_valid <= 1'b1;
            orphan_idx   <= beat_idx;
        end else if (orphan_hit) begin
            orphan_valid <= 1'b0;
        end
    end

    err_flags_t flags, flags_new;
    logic       beat_chk;

    always_comb begin
        beat_chk         = w_fire & head_valid;
        flags_new.bad    = (beat_chk & w_last & (beat_idx != head_len_ext))
                         | (orphan_hit & (orphan_idx != CNT_W'(aw_len)));
        flags_new.absent = beat_chk & ~w_last & (beat_idx == head_len_ext);
        flags_new.order  = beat_chk & (w_id != head_id);
        flags_new.strb   = beat_chk & ((w_strb & ~lane_ok) != '0);
        flags_new.resp   = b_fire & resp_none;
        flags_new.queue  = q_ovf | orphan_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags | flags_new;
    end

    assign err_last_bad    = flags.bad;
    assign err_last_absent = flags.absent;
    assign err_order       = flags.order;
    assign err_strb        = flags.strb;
    assign err_resp_early  = flags.resp;
    assign err_queue       = flags.queue;
endmodule

// File: rtl/wbeat_monitor_sva.sv
module wbeat_monitor_sva #(
    parameter int ID_W  = 4,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             w_fire,
    input logic             w_last,
    input logic             head_valid,
    input logic [CNT_W-1:0] beat_idx,
    input logic [CNT_W-1:0] head_len_ext,
    input logic [ID_W-1:0]  w_id,
    input logic [ID_W-1:0]  head_id,
    input logic             b_fire,
    input logic             resp_none,
    input logic             q_push,
    input logic             q_full,
    input logic             q_pop,
    input logic             err_last_bad,
    input logic             err_last_absent,
    input logic             err_order,
    input logic             err_strb,
    input logic             err_resp_early,
    input logic             err_queue
);
    a_r1_last_misplaced: assert property (@(posedge clk) disable iff (rst)
        (w_fire && w_last && head_valid && beat_idx != head_len_ext) |=> err_last_bad);

    a_r2_last_missing: assert property (@(posedge clk) disable iff (rst)
        (w_fire && !w_last && head_valid && beat_idx == head_len_ext) |=> err_last_absent);

    a_r4_id_order: assert property (@(posedge clk) disable iff (rst)
        (w_fire && head_valid && w_id != head_id) |=> err_order);

    a_r7_resp_early: assert property (@(posedge clk) disable iff (rst)
        (b_fire && resp_none) |=> err_resp_early);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (q_push && q_full && !q_pop) |=> err_queue);

    a_r10_sticky_strb: assert property (@(posedge clk) disable iff (rst)
        err_strb |=> err_strb);

    a_r10_sticky_bad: assert property (@(posedge clk) disable iff (rst)
        err_last_bad |=> err_last_bad);
endmodule

bind wbeat_monitor wbeat_monitor_sva #(.ID_W(ID_W), .CNT_W(CNT_W)) u_sva (
    .clk             (clk),
    .rst             (rst),
    .w_fire          (w_fire),
    .w_last          (w_last),
    .head_valid      (head_valid),
    .beat_idx        (beat_idx),
    .head_len_ext    (head_len_ext),
    .w_id            (w_id),
    .head_id         (head_id),
    .b_fire          (b_fire),
    .resp_none       (resp_none),
    .q_push          (q_push),
    .q_full          (q_full),
    .q_pop           (q_pop),
    .err_last_bad    (err_last_bad),
    .err_last_absent (err_last_absent),
    .err_order       (err_order),
    .err_strb        (err_strb),
    .err_resp_early  (err_resp_early),
    .err_queue       (err_queue)
);

// File: tb/wbeat_monitor_bench.sv
`timescale 1ns/1ps
module wbeat_monitor_bench;
    localparam int ID_W = 4;
    localparam int DATA_W = 32;
    localparam int LANES = DATA_W / 8;

    localparam logic [5:0] F_NONE = 6'b000000;
    localparam logic [5:0] F_BAD  = 6'b000001;
    localparam logic [5:0] F_ABS  = 6'b000010;
    localparam logic [5:0] F_ORD  = 6'b000100;
    localparam logic [5:0] F_STRB = 6'b001000;
    localparam logic [5:0] F_RESP = 6'b010000;
    localparam logic [5:0] F_Q    = 6'b100000;

    localparam logic [1:0] BT_FIXED = 2'b00;
    localparam logic [1:0] BT_INCR  = 2'b01;
    localparam logic [1:0] BT_WRAP  = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic aw_valid = 1'b0, aw_ready = 1'b1;
    logic [ID_W-1:0] aw_id = '0;
    logic [11:0] aw_addr_lo = '0;
    logic [3:0] aw_len = '0;
    logic [2:0] aw_size = '0;
    logic [1:0] aw_burst = '0;
    logic w_valid = 1'b0, w_ready = 1'b1;
    logic [ID_W-1:0] w_id = '0;
    logic [LANES-1:0] w_strb = '0;
    logic w_last = 1'b0;
    logic b_valid = 1'b0, b_ready = 1'b1;
    logic err_last_bad, err_last_absent, err_order, err_strb, err_resp_early, err_queue;

    always #4 clk = ~clk;

    wbeat_monitor #(.ID_W(ID_W), .DATA_W(DATA_W), .MAX_BURSTS(16)) u_wbeat_monitor (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr_lo(aw_addr_lo),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_strb(w_strb), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready),
        .err_last_bad(err_last_bad), .err_last_absent(err_last_absent), .err_order(err_order),
        .err_strb(err_strb), .err_resp_early(err_resp_early), .err_queue(err_queue)
    );

    typedef struct {
        logic [5:0] v;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t item;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [5:0] obs;

    assign obs = {err_queue, err_resp_early, err_strb, err_order, err_last_absent, err_last_bad};

    // monitor: pops expected items and compares against the flag outputs
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item = exp_q.pop_front();
            checks++;
            if (obs !== item.v) begin
                errors++;
                $display("FAIL %s: flags=%b expected=%b", item.tag, obs, item.v);
            end
        end
    end

    task automatic expect_flags(input logic [5:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        aw_valid = 1'b0; w_valid = 1'b0; b_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_aw(input logic [3:0] id, input logic [11:0] a, input logic [3:0] l,
                          input logic [2:0] s, input logic [1:0] b);
        aw_valid = 1'b1; aw_id = id; aw_addr_lo = a; aw_len = l; aw_size = s; aw_burst = b;
    endtask

    task automatic set_w(input logic [3:0] id, input logic [LANES-1:0] st, input logic last);
        w_valid = 1'b1; w_id = id; w_strb = st; w_last = last;
    endtask

    task automatic aw_put(input logic [3:0] id, input logic [11:0] a, input logic [3:0] l,
                          input logic [2:0] s, input logic [1:0] b);
        set_aw(id, a, l, s, b);
        @(negedge clk);
        aw_valid = 1'b0;
    endtask

    task automatic w_put(input logic [3:0] id, input logic [LANES-1:0] st, input logic last);
        set_w(id, st, last);
        @(negedge clk);
        w_valid = 1'b0; w_last = 1'b0;
    endtask

    task automatic aw_w_put(input logic [3:0] id, input logic [11:0] a, input logic [3:0] l,
                            input logic [2:0] s, input logic [1:0] b,
                            input logic [LANES-1:0] st, input logic last);
        set_aw(id, a, l, s, b);
        set_w(id, st, last);
        @(negedge clk);
        aw_valid = 1'b0; w_valid = 1'b0; w_last = 1'b0;
    endtask

    task automatic b_put();
        b_valid = 1'b1;
        @(negedge clk);
        b_valid = 1'b0;
    endtask

    task automatic w_b_put(input logic [3:0] id, input logic [LANES-1:0] st);
        set_w(id, st, 1'b1);
        b_valid = 1'b1;
        @(negedge clk);
        w_valid = 1'b0; w_last = 1'b0; b_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, flags=%b expected=finished", obs);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_flags(F_NONE, "R10 reset clears flags");

        // R1 R2: clean incrementing burst, then legal response (R7)
        aw_put(4'd1, 12'h100, 4'd3, 3'd2, BT_INCR);
        for (int k = 0; k < 4; k++) w_put(4'd1, 4'b1111, k == 3);
        expect_flags(F_NONE, "R1 R2 clean four-beat burst");
        b_put();
        expect_flags(F_NONE, "R7 response after last beat");

        // R1: last beat too early
        do_reset();
        aw_put(4'd2, 12'h000, 4'd3, 3'd2, BT_INCR);
        for (int k = 0; k < 3; k++) w_put(4'd2, 4'b1111, k == 2);
        expect_flags(F_BAD, "R1 early last beat");
        repeat (4) @(negedge clk);
        expect_flags(F_BAD, "R10 flag stays set");

        // R2: last beat missing
        do_reset();
        aw_put(4'd2, 12'h000, 4'd1, 3'd2, BT_INCR);
        w_put(4'd2, 4'b1111, 1'b0);
        w_put(4'd2, 4'b1111, 1'b0);
        expect_flags(F_ABS, "R2 missing last beat");

        // R3: data before address, matching and mismatching
        do_reset();
        w_put(4'd4, 4'b1111, 1'b0);
        w_put(4'd4, 4'b1111, 1'b1);
        aw_put(4'd4, 12'h000, 4'd1, 3'd2, BT_INCR);
        expect_flags(F_NONE, "R3 held count matches late address");
        do_reset();
        for (int k = 0; k < 3; k++) w_put(4'd4, 4'b1111, k == 2);
        aw_put(4'd4, 12'h000, 4'd1, 3'd2, BT_INCR);
        expect_flags(F_BAD, "R3 held count mismatches late address");

        // R4: data ID does not follow address order
        do_reset();
        aw_put(4'd3, 12'h000, 4'd0, 3'd2, BT_INCR);
        aw_put(4'd5, 12'h000, 4'd0, 3'd2, BT_INCR);
        w_put(4'd5, 4'b1111, 1'b1);
        expect_flags(F_ORD, "R4 data for younger address first");

        // R5: unaligned incrementing start
        do_reset();
        aw_put(4'd1, 12'h101, 4'd1, 3'd2, BT_INCR);
        w_put(4'd1, 4'b1110, 1'b0);
        w_put(4'd1, 4'b1111, 1'b1);
        expect_flags(F_NONE, "R5 unaligned first beat legal lanes");
        do_reset();
        aw_put(4'd1, 12'h101, 4'd1, 3'd2, BT_INCR);
        w_put(4'd1, 4'b1111, 1'b0);
        w_put(4'd1, 4'b1111, 1'b1);
        expect_flags(F_STRB, "R5 unaligned first beat lane below start");

        // R5: narrow incrementing beats walk across lanes
        do_reset();
        aw_put(4'd1, 12'h002, 4'd2, 3'd0, BT_INCR);
        w_put(4'd1, 4'b0100, 1'b0);
        w_put(4'd1, 4'b1000, 1'b0);
        w_put(4'd1, 4'b0001, 1'b1);
        expect_flags(F_NONE, "R5 narrow beats lanes 2,3,0");

        // R6: wrapping burst with a window smaller than the bus
        do_reset();
        aw_put(4'd1, 12'h003, 4'd1, 3'd0, BT_WRAP);
        w_put(4'd1, 4'b1000, 1'b0);
        w_put(4'd1, 4'b0100, 1'b1);
        expect_flags(F_NONE, "R6 wrap returns to byte 2");
        do_reset();
        aw_put(4'd1, 12'h003, 4'd1, 3'd0, BT_WRAP);
        w_put(4'd1, 4'b1000, 1'b0);
        w_put(4'd1, 4'b0001, 1'b1);
        expect_flags(F_STRB, "R6 wrap beat on linear lane");

        // R6: fixed burst repeats its lane
        do_reset();
        aw_put(4'd1, 12'h001, 4'd2, 3'd0, BT_FIXED);
        for (int k = 0; k < 3; k++) w_put(4'd1, 4'b0010, k == 2);
        expect_flags(F_NONE, "R6 fixed burst same lane");
        do_reset();
        aw_put(4'd1, 12'h001, 4'd1, 3'd0, BT_FIXED);
        w_put(4'd1, 4'b0010, 1'b0);
        w_put(4'd1, 4'b0100, 1'b1);
        expect_flags(F_STRB, "R6 fixed burst moved lane");

        // R7: response before completion, and in the same cycle as last beat
        do_reset();
        aw_put(4'd1, 12'h000, 4'd3, 3'd2, BT_INCR);
        w_put(4'd1, 4'b1111, 1'b0);
        w_put(4'd1, 4'b1111, 1'b0);
        b_put();
        expect_flags(F_RESP, "R7 response mid-burst");
        do_reset();
        aw_put(4'd1, 12'h000, 4'd0, 3'd2, BT_INCR);
        w_b_put(4'd1, 4'b1111);
        expect_flags(F_RESP, "R7 response with last beat");

        // R8: queue boundary and overflow
        do_reset();
        for (int k = 0; k < 16; k++) aw_put(4'd6, 12'h000, 4'd0, 3'd2, BT_INCR);
        expect_flags(F_NONE, "R8 queue full without overflow");
        aw_put(4'd6, 12'h000, 4'd0, 3'd2, BT_INCR);
        expect_flags(F_Q, "R8 address into full queue");
        do_reset();
        w_put(4'd2, 4'b1111, 1'b1);
        w_put(4'd2, 4'b1111, 1'b1);
        expect_flags(F_Q, "R8 second address-less burst");

        // R9: address and data in the same cycle
        do_reset();
        aw_w_put(4'd1, 12'h003, 4'd0, 3'd0, BT_INCR, 4'b1000, 1'b1);
        w_put(4'd9, 4'b1111, 1'b1);
        expect_flags(F_NONE, "R9 same-cycle address used and retired");
        do_reset();
        aw_w_put(4'd1, 12'h003, 4'd0, 3'd0, BT_INCR, 4'b0001, 1'b1);
        expect_flags(F_STRB, "R9 same-cycle address judges strobe");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule